// File: doc/BRIEF.md
# Power Mode and System Clock Controller

This block decides how a small processor core spends power. Two software registers configure it. One chooses the system clock source: the fast clock at full rate, the fast clock divided by a power of two from 2 to 64, or the slow oscillator. The other holds the idle behaviour and the status flags. A one-cycle halt request from the core moves the block into one of three low-power modes. The mode depends on two configuration bits. A wake-up request brings the block back to normal running. The CPU clock resumes only once the oscillator behind the selected source reports that it is ready.

Clocks are modelled as enables. `clk` stands for the fast oscillator. `lirc_tick` is a one-cycle pulse per slow-oscillator period. `sys_clk_en` and `cpu_clk_en` are the gated enables handed to the peripherals and to the core. `hosc_en` switches the fast oscillator on and off. It goes low whenever the slow oscillator drives the system, and in the two modes that stop the system clock. A sticky flag records low-voltage reset events. Software can clear this flag but cannot set it.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After synchronous reset the control register (address 0) reads 0x01 and the status register (address 1) reads 0x00. The mode output is 0 (run) and `hosc_en` is 1.
- R2: With the idle-enable bit (address 0, bit 4) at 0, a halt request in run mode sets mode to 1 (sleep). After that, `sys_clk_en` and `cpu_clk_en` stay 0.
- R3: With idle-enable at 1 and the clock-in-idle bit (address 1, bit 3) at 1, a halt request sets mode to 3. In this mode `cpu_clk_en` stays 0 while `sys_clk_en` keeps pulsing at the selected rate.
- R4: With idle-enable at 1 and clock-in-idle at 0, a halt request sets mode to 2. Both enables then stay 0.
- R5: With the fast-select bit (address 0, bit 0) at 1 in run mode, `sys_clk_en` and `cpu_clk_en` are high in every cycle.
- R6: With fast-select at 0, the divider code k (address 0, bits 3:1) gives one enable pulse every 2^(k+1) cycles for k from 0 to 5. Codes 6 and 7 follow `lirc_tick`.
- R7: `hosc_en` is 0 while fast-select is 0 with divider code 6 or 7. It is also 0 in modes 1 and 2, and 1 otherwise.
- R8: The slow-ready flag (address 1, bit 1) is 0 while sleeping. After a wake-up it sets on the first `lirc_tick` that arrives with `losc_stable` high.
- R9: The fast-ready flag (address 1, bit 0) is 0 after reset. It sets one cycle after `hosc_en` and `hosc_stable` are both high.
- R10: The low-voltage flag (address 1, bit 2) is set by `lvr_evt`. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clear wins.
- R11: A wake request in mode 1, 2 or 3 moves the block to mode 4 (waking). It goes to mode 0 only when the ready flag of the selected source is 1. `cpu_clk_en` stays 0 until then.
- R12: A halt request outside mode 0 and a wake request in mode 0 are ignored. Register bits with no function read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered one cycle after the address |
| halt_req | input | 1 | One-cycle halt request from the core |
| wake_req | input | 1 | Wake-up request |
| hosc_stable | input | 1 | Fast oscillator reports stable |
| losc_stable | input | 1 | Slow oscillator reports stable |
| lirc_tick | input | 1 | One pulse per slow-oscillator period |
| lvr_evt | input | 1 | Low-voltage reset event |
| hosc_en | output | 1 | Fast oscillator enable |
| sys_clk_en | output | 1 | System (peripheral) clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| mode | output | 3 | 0 run, 1 sleep, 2 idle clock off, 3 idle clock on, 4 waking |

## Verification
A wrong mode register appears on `mode` one cycle after the halt or wake edge. It shows on the two clock enables and on `hosc_en` a cycle after that. A stuck wait state shows as a core that never regains `cpu_clk_en`. A wrong divider code or source pick shows as a wrong pulse count over any window that is a whole multiple of the period. A corrupted ready or low-voltage flag appears on the next status read. A wrong ready flag also shows as a wake-up that finishes too early or never finishes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_SLEEP = 3'd1,
    PM_IDLE0 = 3'd2,
    PM_IDLE1 = 3'd3,
    PM_WAKE  = 3'd4
  } pm_mode_e;
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lvr_evt,
  input  logic              hrdy,
  input  logic              lrdy,
  output logic              fast_sel,
  output logic [CODE_W-1:0] div_code,
  output logic              idle_en,
  output logic              sys_in_idle,
  output logic              lvr_flag,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDLE_BIT = CODE_W + 1;
  localparam int ST_HRDY  = 0;
  localparam int ST_LRDY  = 1;
  localparam int ST_LVR   = 2;
  localparam int ST_SYSI  = 3;

  logic [DATA_W-1:0] ctl_img, stat_img;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:IDLE_BIT+1];

  always_comb begin
    ctl_img               = '0;
    ctl_img[0]            = fast_sel;
    ctl_img[CODE_W:1]     = div_code;
    ctl_img[IDLE_BIT]     = idle_en;
    stat_img              = '0;
    stat_img[ST_HRDY]     = hrdy;
    stat_img[ST_LRDY]     = lrdy;
    stat_img[ST_LVR]      = lvr_flag;
    stat_img[ST_SYSI]     = sys_in_idle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_sel    <= 1'b1;
      div_code    <= '0;
      idle_en     <= 1'b0;
      sys_in_idle <= 1'b0;
      lvr_flag    <= 1'b0;
      rdata       <= '0;
    end else begin
      if (we && !addr) begin
        fast_sel <= wdata[0];
        div_code <= wdata[CODE_W:1];
        idle_en  <= wdata[IDLE_BIT];
      end
      if (we && addr) sys_in_idle <= wdata[ST_SYSI];
      if (lvr_evt) lvr_flag <= 1'b1;
      else if (we && addr && !wdata[ST_LVR]) lvr_flag <= 1'b0;
      rdata <= addr ? stat_img : ctl_img;
    end
  end
endmodule

// File: rtl/pcc_clkgen.sv
module pcc_clkgen #(
  parameter int CODE_W     = 3,
  parameter int DIV_STAGES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              lirc_tick,
  output logic              raw_tick,
  output logic              uses_fl
);
  localparam int NCODES = 2 ** CODE_W;
  localparam logic [CODE_W-1:0] FL_CODE = CODE_W'(DIV_STAGES);

  logic [DIV_STAGES-1:0] cnt;
  logic [NCODES-1:0]     code_tick;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NCODES; k++) begin : g_code
    if (k < DIV_STAGES) begin : g_div
      assign code_tick[k] = &cnt[k:0];
    end else begin : g_slow
      assign code_tick[k] = lirc_tick;
    end
  end

  assign uses_fl  = !fast_sel && (div_code >= FL_CODE);
  assign raw_tick = fast_sel ? 1'b1 : code_tick[div_code];
endmodule

// File: rtl/pcc_ready.sv
module pcc_ready
  import pcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_mode_e mode,
  input  logic     hosc_en,
  input  logic     hosc_stable,
  input  logic     losc_stable,
  input  logic     lirc_tick,
  output logic     hrdy,
  output logic     lrdy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hrdy <= 1'b0;
      lrdy <= 1'b0;
    end else begin
      hrdy <= hosc_en && hosc_stable;
      if (mode == PM_SLEEP)                lrdy <= 1'b0;
      else if (lirc_tick && losc_stable)   lrdy <= 1'b1;
    end
  end
endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     halt_req,
  input  logic     wake_req,
  input  logic     idle_en,
  input  logic     sys_in_idle,
  input  logic     sel_ready,
  output pm_mode_e mode
);
  pm_mode_e nxt;

  always_comb begin
    nxt = mode;
    unique case (mode)
      PM_RUN: if (halt_req) begin
        if (!idle_en)        nxt = PM_SLEEP;
        else if (sys_in_idle) nxt = PM_IDLE1;
        else                 nxt = PM_IDLE0;
      end
      PM_SLEEP, PM_IDLE0, PM_IDLE1: if (wake_req) nxt = PM_WAKE;
      PM_WAKE: if (sel_ready) nxt = PM_RUN;
      default: nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= PM_RUN;
    else     mode <= nxt;
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CODE_W     = 3,
  parameter int DIV_STAGES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              halt_req,
  input  logic              wake_req,
  input  logic              hosc_stable,
  input  logic              losc_stable,
  input  logic              lirc_tick,
  input  logic              lvr_evt,
  output logic              hosc_en,
  output logic              sys_clk_en,
  output logic              cpu_clk_en,
  output logic [2:0]        mode
);
  logic              fast_sel_w, idle_en_w, sys_in_idle_w, lvr_flag_w;
  logic [CODE_W-1:0] div_code_w;
  logic              hrdy_w, lrdy_w, raw_tick_w, uses_fl_w, sel_ready_w;
  pm_mode_e          mode_w;

  pcc_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .lvr_evt(lvr_evt), .hrdy(hrdy_w), .lrdy(lrdy_w),
    .fast_sel(fast_sel_w), .div_code(div_code_w), .idle_en(idle_en_w),
    .sys_in_idle(sys_in_idle_w), .lvr_flag(lvr_flag_w), .rdata(reg_rdata)
  );

  pcc_clkgen #(.CODE_W(CODE_W), .DIV_STAGES(DIV_STAGES)) clkgen_i (
    .clk(clk), .rst(rst), .fast_sel(fast_sel_w), .div_code(div_code_w),
    .lirc_tick(lirc_tick), .raw_tick(raw_tick_w), .uses_fl(uses_fl_w)
  );

  pcc_ready ready_i (
    .clk(clk), .rst(rst), .mode(mode_w), .hosc_en(hosc_en),
    .hosc_stable(hosc_stable), .losc_stable(losc_stable),
    .lirc_tick(lirc_tick), .hrdy(hrdy_w), .lrdy(lrdy_w)
  );

  assign sel_ready_w = uses_fl_w ? lrdy_w : hrdy_w;

  pcc_mode_fsm fsm_i (
    .clk(clk), .rst(rst), .halt_req(halt_req), .wake_req(wake_req),
    .idle_en(idle_en_w), .sys_in_idle(sys_in_idle_w),
    .sel_ready(sel_ready_w), .mode(mode_w)
  );

  logic sys_gate, fast_off;
  assign sys_gate = (mode_w == PM_RUN) || (mode_w == PM_IDLE1);
  assign fast_off = uses_fl_w || (mode_w == PM_SLEEP) || (mode_w == PM_IDLE0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hosc_en    <= 1'b1;
      sys_clk_en <= 1'b0;
      cpu_clk_en <= 1'b0;
    end else begin
      hosc_en    <= !fast_off;
      sys_clk_en <= raw_tick_w && sys_gate;
      cpu_clk_en <= raw_tick_w && (mode_w == PM_RUN);
    end
  end

  assign mode = mode_w;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       halt_req,
  input logic       wake_req,
  input logic       lvr_evt,
  input logic       lvr_flag,
  input logic       lrdy,
  input logic       sys_clk_en,
  input logic       cpu_clk_en,
  input logic       hosc_en,
  input logic       uses_fl,
  input logic       sel_ready
);
  localparam logic [2:0] M_RUN = 3'd0, M_SLP = 3'd1, M_I0 = 3'd2, M_I1 = 3'd3, M_WK = 3'd4;

  p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SLP && $past(mode) == M_SLP) |-> (!sys_clk_en && !cpu_clk_en));

  p_idle1_no_cpu_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == M_I1) |-> !cpu_clk_en);

  p_idle0_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == M_I0 && $past(mode) == M_I0) |-> (!sys_clk_en && !cpu_clk_en));

  p_fast_off_slow_r7: assert property (@(posedge clk) disable iff (rst)
    $past(uses_fl) |-> !hosc_en);

  p_lrdy_low_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SLP && $past(mode) == M_SLP) |-> !lrdy);

  p_lvr_sets_r10: assert property (@(posedge clk) disable iff (rst)
    $past(lvr_evt) |-> lvr_flag);

  p_lvr_hw_only_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(lvr_flag) |-> $past(lvr_evt));

  p_cpu_run_only_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> ($past(mode) == M_RUN));

  p_wake_needs_ready_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == M_WK && mode == M_RUN) |-> $past(sel_ready));

  p_halt_in_sleep_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == M_SLP && $past(halt_req) && !$past(wake_req)) |-> (mode == M_SLP));
endmodule

bind pwr_clk_ctrl pcc_checker chk_i (
  .clk(clk), .rst(rst), .mode(mode), .halt_req(halt_req), .wake_req(wake_req),
  .lvr_evt(lvr_evt), .lvr_flag(lvr_flag_w), .lrdy(lrdy_w),
  .sys_clk_en(sys_clk_en), .cpu_clk_en(cpu_clk_en), .hosc_en(hosc_en),
  .uses_fl(uses_fl_w), .sel_ready(sel_ready_w)
);

// File: tb/pwr_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       halt_req = 1'b0, wake_req = 1'b0;
  logic       hosc_stable = 1'b0, losc_stable = 1'b1, lirc_tick = 1'b0, lvr_evt = 1'b0;
  logic       hosc_en, sys_clk_en, cpu_clk_en;
  logic [2:0] mode;
  int         checks = 0, errors = 0;
  logic [2:0] lcnt = '0;

  always #2 clk = ~clk;

  pwr_clk_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt_req(halt_req),
    .wake_req(wake_req), .hosc_stable(hosc_stable), .losc_stable(losc_stable),
    .lirc_tick(lirc_tick), .lvr_evt(lvr_evt), .hosc_en(hosc_en),
    .sys_clk_en(sys_clk_en), .cpu_clk_en(cpu_clk_en), .mode(mode)
  );

  // slow oscillator model: one pulse every 8 fast cycles
  always @(negedge clk) begin
    lcnt      <= lcnt + 3'd1;
    lirc_tick <= (lcnt == 3'd7);
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
  endtask

  task automatic count(input int n, output int s, output int c);
    s = 0; c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s += int'(sys_clk_en);
      c += int'(cpu_clk_en);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s, c, em, n;
    string tg;
    idle(5);
    @(negedge clk); rst = 1'b0;
    // R1 reset state, R9 fast-ready low while oscillator not stable
    rd(1'b0, d); check("R1 ctl reset", d, 8'h01);
    rd(1'b1, d); check("R1 stat reset", d & 8'hFD, 8'h00);
    check("R9 hrdy after reset", d[0], 0);
    check("R1 mode", mode, 0);
    check("R1 hosc_en", hosc_en, 1);
    hosc_stable = 1'b1;
    idle(3);
    rd(1'b1, d); check("R9 hrdy set", d[0], 1);

    // R5 full rate
    count(128, s, c);
    check("R5 sys full", s, 128); check("R5 cpu full", c, 128);

    // R6 divided rates, R7 fast oscillator gating
    for (int k = 0; k < 8; k++) begin
      wr(1'b0, 8'(k << 1));
      idle(4);
      count(128, s, c);
      check("R6 sys div", s, (k < 6) ? (128 >> (k + 1)) : 16);
      check("R6 cpu div", c, (k < 6) ? (128 >> (k + 1)) : 16);
      check("R7 hosc_en by code", hosc_en, (k < 6) ? 1 : 0);
    end

    // R2 R3 R4 halt under every control combination, R11 wake
    for (int ie = 0; ie < 2; ie++) begin
      for (int si = 0; si < 2; si++) begin
        wr(1'b0, 8'(1 | (ie << 4)));
        wr(1'b1, 8'(si << 3));
        pulse_halt();
        idle(2);
        em = (ie == 0) ? 1 : ((si == 1) ? 3 : 2);
        tg = (em == 1) ? "R2" : ((em == 3) ? "R3" : "R4");
        check({tg, " mode"}, mode, em);
        count(64, s, c);
        check({tg, " sys"}, s, (em == 3) ? 64 : 0);
        check({tg, " cpu"}, c, 0);
        check("R7 hosc_en in low power", hosc_en, (em == 3) ? 1 : 0);
        if (em == 1) begin
          rd(1'b1, d); check("R8 lrdy in sleep", d[1], 0);
        end
        if (em != 3) begin
          hosc_stable = 1'b0;
          pulse_wake();
          count(10, s, c);
          check("R11 held in wake", mode, 4);
          check("R11 no cpu before ready", c, 0);
          hosc_stable = 1'b1;
          idle(5);
        end else begin
          pulse_wake();
          idle(4);
        end
        check("R11 back to run", mode, 0);
        count(16, s, c);
        check("R11 cpu after wake", c, 16);
      end
    end

    // R12 wake in run ignored
    pulse_wake(); idle(1);
    check("R12 wake in run", mode, 0);

    // R8 slow source: sleep, halt ignored, wake on first slow tick
    wr(1'b0, 8'h0C);
    idle(4);
    check("R7 hosc off slow", hosc_en, 0);
    pulse_halt(); idle(3);
    check("R2 sleep slow", mode, 1);
    rd(1'b1, d); check("R8 lrdy sleep slow", d[1], 0);
    pulse_halt(); idle(1);
    check("R12 halt in sleep", mode, 1);
    pulse_wake();
    n = 0;
    while (mode != 3'd0 && n < 20) begin
      @(negedge clk); n++;
    end
    check("R8 wake within slow tick", (n >= 1 && n <= 9) ? 1 : 0, 1);
    rd(1'b1, d); check("R8 lrdy after wake", d[1], 1);
    count(64, s, c); check("R6 cpu slow after wake", c, 8);

    // R12 unimplemented bits read zero
    wr(1'b0, 8'hE1);
    rd(1'b0, d); check("R12 ctl spare bits", d, 8'h01);
    wr(1'b1, 8'hF0);
    rd(1'b1, d); check("R12 stat spare bits", d & 8'hF0, 0);

    // R10 sticky low-voltage flag
    rd(1'b1, d); check("R10 flag clear", d[2], 0);
    wr(1'b1, 8'h04);
    rd(1'b1, d); check("R10 write one no set", d[2], 0);
    @(negedge clk); lvr_evt = 1'b1; @(negedge clk); lvr_evt = 1'b0;
    rd(1'b1, d); check("R10 event sets", d[2], 1);
    wr(1'b1, 8'h04);
    rd(1'b1, d); check("R10 write one keeps", d[2], 1);
    @(negedge clk); lvr_evt = 1'b1; reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); lvr_evt = 1'b0; reg_we = 1'b0;
    rd(1'b1, d); check("R10 event beats clear", d[2], 1);
    wr(1'b1, 8'h00);
    rd(1'b1, d); check("R10 write zero clears", d[2], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule